// File: doc/BRIEF.md
# Output Selector with Override and Held Side Bit

This block drives a 5-bit output port and one extra side bit. The 5-bit port can show the live 5-bit input port or one of two stored 6-bit words (store A, store B). Three things decide which source is shown: a 2-bit source code, a mux-select pin and an active-low override pin. The source code arrives with each byte written over a serial bus. It becomes active only when the bus logic reports a STOP condition.

Each written byte has two parts. Bits 7:6 carry the source code and also name the destination store (00 = A, 01 = B). Bits 5:0 carry the data. A stored word does not change at once. The block models a slow non-volatile update with a countdown of `WRITE_DELAY` clock cycles, and shows a busy flag while the countdown runs. The side bit comes from a register that follows its source while mux-select is low and keeps its value while mux-select is high.

The block sits behind a serial-bus slave. The slave passes it each write byte as a one-cycle strobe and reports each STOP as a one-cycle pulse.

Top module: `outsel_top`

## Requirements
- R1: While `ovrd_n` is 0, `y_out` and `side_out` are 0 one cycle later, whatever the other inputs are.
- R2: While `ovrd_n` is 1 and `mux_sel` is 1, `y_out` equals `in_port` from the previous cycle.
- R3: While `ovrd_n` is 1 and `mux_sel` is 0, the active source code picks the output. Code 10 passes `in_port`. Code 00 passes store A and code 01 passes store B, each mapped as `y_out[4]` = store bit 5 and `y_out[3:0]` = store bits 3:0.
- R4: Reset sets the active source code to 10, clears both stores, drives `y_out` and `side_out` to 0 and clears `busy`.
- R5: The code in bits 7:6 of a written byte becomes active only on the next `stop_pulse`. Until that pulse, the earlier active code stays in effect.
- R6: A STOP that finds code 11 pending leaves the earlier active code unchanged.
- R7: While `mux_sel` is 0 and `ovrd_n` is 1, `side_out` follows bit 4 of store B when the active code is 01. For any other active code it follows bit 4 of store A.
- R8: While `mux_sel` is 1, `side_out` keeps the value it had in the last cycle `mux_sel` was 0. A change of store or of source code does not alter it.
- R9: A write with bits 7:6 = 00 or 01 loads bits 5:0 into store A or store B `WRITE_DELAY` cycles later. `busy` is 1 from the cycle after the write until the store takes the data.
- R10: A write aimed at a store that is still counting down leaves that store's data unchanged. A write with bits 7:6 = 10 or 11 loads no store and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_port | input | 5 | Live input port |
| mux_sel | input | 1 | 1 forces the input port onto `y_out` and holds the side bit |
| ovrd_n | input | 1 | Active-low override; 0 forces all outputs to 0 |
| wr_valid | input | 1 | One-cycle strobe for a bus write byte |
| wr_byte | input | 8 | Write byte: [7:6] source code / store select, [5:0] data |
| stop_pulse | input | 1 | One-cycle pulse when a bus STOP is seen |
| y_out | output | 5 | Registered 5-bit output port |
| side_out | output | 1 | Registered side bit from the held register |
| busy | output | 1 | A store update is counting down |

## Verification
The hardest state to reach is a store that is still counting down while a new code is pending and not yet active. The pending code and the slow store update then act on the output at different times. The stimulus writes store B twice, a few cycles apart, so the second write lands during the countdown. It then waits well beyond the delay before sending STOP. This shows that the output kept the earlier source until the STOP, and that the second write left store B unchanged. The side-bit hold is checked in a similar way: `mux_sel` is raised, and then the source is moved to a store whose bit 4 differs from the held value.

// File: rtl/outsel_pkg.sv
package outsel_pkg;
  localparam int unsigned PORT_W  = 5;
  localparam int unsigned STORE_W = 6;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NSTORE  = 2;

  typedef enum logic [1:0] {
    SRC_A    = 2'b00,
    SRC_B    = 2'b01,
    SRC_PORT = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  // store word -> port value: bit5 to top, bits 3:0 below, bit 4 is the side bit
  function automatic logic [PORT_W-1:0] store_to_port(input logic [STORE_W-1:0] w);
    return {w[5], w[3:0]};
  endfunction
endpackage

// File: rtl/outsel_code.sv
module outsel_code
  import outsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [1:0]        wr_code,
  input  logic              stop_pulse,
  output src_e              code_q
);
  src_e pend_q;
  logic pend_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= SRC_PORT;
      pend_q   <= SRC_PORT;
      pend_vld <= 1'b0;
    end else begin
      if (stop_pulse) begin
        if (pend_vld && pend_q != SRC_RSVD) code_q <= pend_q;
        pend_vld <= 1'b0;
      end
      if (wr_valid) begin
        pend_q   <= src_e'(wr_code);
        pend_vld <= 1'b1;
      end
    end
  end

  AST_CODE_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    !stop_pulse |=> $stable(code_q)); // R5

  always_comb begin
    if (!rst) AST_CODE_NOT_RSVD: assert (code_q != SRC_RSVD); // R6
  end
endmodule

// File: rtl/outsel_store.sv
module outsel_store
  import outsel_pkg::*;
#(
  parameter logic [1:0]  IDX         = 2'b00,
  parameter int unsigned WRITE_DELAY = 2000000,
  localparam int unsigned CNT_W      = $clog2(WRITE_DELAY + 1)
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [BYTE_W-1:0]  wr_byte,
  output logic [STORE_W-1:0] data_q,
  output logic               busy_q
);
  logic [STORE_W-1:0] stage_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               take;

  assign take = wr_valid && (wr_byte[7:6] == IDX) && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      stage_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (take) begin
      stage_q <= wr_byte[STORE_W-1:0];
      cnt_q   <= CNT_W'(WRITE_DELAY - 1);
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        data_q <= stage_q;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_STORE_HOLD_WHILE_COUNTING: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> $stable(data_q)); // R9

  AST_IDLE_STORE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> $stable(data_q)); // R10
endmodule

// File: rtl/outsel_drive.sv
module outsel_drive
  import outsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [PORT_W-1:0]  in_port,
  input  logic               mux_sel,
  input  logic               ovrd_n,
  input  src_e               code,
  input  logic [STORE_W-1:0] st_a,
  input  logic [STORE_W-1:0] st_b,
  output logic [PORT_W-1:0]  y_q,
  output logic               side_q
);
  logic [PORT_W-1:0] y_nxt;
  logic              side_src;
  logic              side_lat;

  always_comb begin
    unique case (code)
      SRC_A:   y_nxt = store_to_port(st_a);
      SRC_B:   y_nxt = store_to_port(st_b);
      default: y_nxt = in_port;
    endcase
    if (mux_sel) y_nxt = in_port;
    side_src = (code == SRC_B) ? st_b[4] : st_a[4];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      side_lat <= 1'b0;
      y_q      <= '0;
      side_q   <= 1'b0;
    end else begin
      if (!mux_sel) side_lat <= side_src;
      y_q    <= ovrd_n ? y_nxt : '0;
      side_q <= ovrd_n ? (mux_sel ? side_lat : side_src) : 1'b0;
    end
  end

  AST_OVERRIDE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !ovrd_n |=> (y_q == '0 && !side_q)); // R1

  AST_MUXSEL_PASSES_PORT: assert property (@(posedge clk) disable iff (rst)
    (ovrd_n && mux_sel) |=> y_q == $past(in_port)); // R2

  AST_SIDE_HELD: assert property (@(posedge clk) disable iff (rst)
    mux_sel |=> $stable(side_lat)); // R8
endmodule

// File: rtl/outsel_top.sv
module outsel_top
  import outsel_pkg::*;
#(
  parameter int unsigned WRITE_DELAY = 2000000
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        in_port,
  input  logic              mux_sel,
  input  logic              ovrd_n,
  input  logic              wr_valid,
  input  logic [7:0]        wr_byte,
  input  logic              stop_pulse,
  output logic [4:0]        y_out,
  output logic              side_out,
  output logic              busy
);
  src_e               code;
  logic [STORE_W-1:0] st_data [NSTORE];
  logic [NSTORE-1:0]  st_busy;

  outsel_code u_code (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_code(wr_byte[7:6]),
    .stop_pulse(stop_pulse), .code_q(code)
  );

  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    outsel_store #(.IDX(2'(g)), .WRITE_DELAY(WRITE_DELAY)) u_store (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_byte(wr_byte),
      .data_q(st_data[g]), .busy_q(st_busy[g])
    );
  end

  outsel_drive u_drive (
    .clk(clk), .rst(rst), .in_port(in_port), .mux_sel(mux_sel), .ovrd_n(ovrd_n),
    .code(code), .st_a(st_data[0]), .st_b(st_data[1]),
    .y_q(y_out), .side_q(side_out)
  );

  assign busy = |st_busy;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (y_out == '0 && !side_out && !busy)); // R4
endmodule

// File: tb/outsel_top_bench.sv
module outsel_top_bench;
  localparam int DLY = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] in_port = 5'h15;
  logic       mux_sel = 1'b0;
  logic       ovrd_n = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       stop_pulse = 1'b0;
  logic [4:0] y_out;
  logic       side_out;
  logic       busy;

  typedef struct {
    string      req;
    logic [4:0] y;
    logic       side;
    logic       bsy;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  always #2.5 clk = ~clk;

  outsel_top #(.WRITE_DELAY(DLY)) u_outsel_top (
    .clk(clk), .rst(rst), .in_port(in_port), .mux_sel(mux_sel), .ovrd_n(ovrd_n),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .stop_pulse(stop_pulse),
    .y_out(y_out), .side_out(side_out), .busy(busy)
  );

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (y_out !== e.y || side_out !== e.side || busy !== e.bsy) begin
        n_fail++;
        $display("FAIL %s: y=%h side=%b busy=%b expected y=%h side=%b busy=%b",
                 e.req, y_out, side_out, busy, e.y, e.side, e.bsy);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [4:0] y,
                            input logic side, input logic bsy);
    exp_t e;
    @(posedge clk); #1;
    e.req = req; e.y = y; e.side = side; e.bsy = bsy;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_byte = b;
    @(negedge clk); wr_valid = 1'b0; wr_byte = '0;
  endtask

  task automatic stop();
    @(negedge clk); stop_pulse = 1'b1;
    @(negedge clk); stop_pulse = 1'b0;
  endtask

  initial begin
    cyc(3);
    expect_out("R4", 5'h00, 1'b0, 1'b0);          // R4 outputs cleared in reset
    @(negedge clk); rst = 1'b0;
    cyc(3);
    expect_out("R4", 5'h15, 1'b0, 1'b0);          // R4 default code 10 passes port

    mux_sel = 1'b1; in_port = 5'h0A; cyc(3);
    expect_out("R2", 5'h0A, 1'b0, 1'b0);          // R2
    mux_sel = 1'b0; cyc(3);
    expect_out("R3", 5'h0A, 1'b0, 1'b0);          // R3 code 10

    wr(8'h35);                                    // store A <- 110101, code 00 pending
    cyc(1);
    expect_out("R9", 5'h0A, 1'b0, 1'b1);          // R9 busy, code not yet active
    stop(); cyc(2);
    expect_out("R9", 5'h00, 1'b0, 1'b1);          // R9 A still old while counting
    cyc(DLY + 5);
    expect_out("R9", 5'h15, 1'b1, 1'b0);          // R9 A loaded, R7 side = A[4]

    wr(8'h4C); cyc(1);                            // store B <- 001100
    wr(8'h7F);                                    // R10 ignored, B busy
    cyc(DLY + 10);
    expect_out("R5", 5'h15, 1'b1, 1'b0);          // R5 code 01 not active before STOP
    stop(); cyc(2);
    expect_out("R10", 5'h0C, 1'b0, 1'b0);         // R10 second write dropped; R3 code 01

    wr(8'hC0); cyc(2);
    expect_out("R10", 5'h0C, 1'b0, 1'b0);         // R10 code 11 loads no store
    stop(); cyc(2);
    expect_out("R6", 5'h0C, 1'b0, 1'b0);          // R6 code 11 keeps 01

    wr(8'h35); cyc(DLY + 5); stop(); cyc(2);
    expect_out("R7", 5'h15, 1'b1, 1'b0);          // R7 side follows A[4]=1

    mux_sel = 1'b1; in_port = 5'h03; cyc(2);
    wr(8'h4C); cyc(DLY + 5); stop(); cyc(2);
    expect_out("R8", 5'h03, 1'b1, 1'b0);          // R8 side held though B[4]=0
    mux_sel = 1'b0; cyc(3);
    expect_out("R7", 5'h0C, 1'b0, 1'b0);          // R7 transparent again, B[4]=0

    ovrd_n = 1'b0; cyc(2);
    expect_out("R1", 5'h00, 1'b0, 1'b0);          // R1
    mux_sel = 1'b1; cyc(2);
    expect_out("R1", 5'h00, 1'b0, 1'b0);          // R1 with mux_sel high
    ovrd_n = 1'b1; mux_sel = 1'b0; cyc(3);
    expect_out("R1", 5'h0C, 1'b0, 1'b0);          // R1 released

    wr(8'h80); cyc(1);
    expect_out("R10", 5'h0C, 1'b0, 1'b0);         // R10 code 10 loads no store
    stop(); cyc(2);
    expect_out("R3", 5'h03, 1'b1, 1'b0);          // R3 code 10 back to port; R7 A[4]

    cyc(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule